// File: doc/BRIEF.md
# Up-Down PWM Time-Base with Compare

This block generates one PWM waveform from a time-base counter. The system clock is divided by two cascaded prescaler stages, and the counter advances on each time-base tick. It can count up, count down, count up and then down, or hold. The period and compare values each have a shadow copy and an active copy. By default a new value goes into the shadow and becomes active when the counter reaches zero, so a running waveform never sees a value changed in the middle of a cycle. An action qualifier sets the PWM output on an up-counting compare match and clears it on a down-counting match.

Software configures the block through a single-word write port while the global run enable is low, then raises run enable to start counting. The counter value, the count direction and four event levels (zero, period, compare-up, compare-down) are exported for a downstream event-trigger block.

Register select `wr_sel`: 0 = control, 1 = period, 2 = compare, 3 = counter. Control word fields: bits [1:0] counting mode, bit 2 period-immediate, bit 3 compare-immediate, bits [6:4] high-speed divider code, bits [9:7] second divider code.

Top module: `pwm_timebase`

## Requirements
- R1: The time-base tick rate is the clock divided by the product of two stage ratios. The high-speed code k (control bits [6:4]) gives a ratio of 1 when k=0 and 2k otherwise, so code 3 is divide-by-6. The second code k (control bits [9:7]) gives a ratio of 2^k. After run enable rises, the first tick falls on the N-th rising clock edge, where N is that product.
- R2: Mode code 3 (control bits [1:0]) freezes the counter: it holds its value on every tick and no events are signalled.
- R3: Mode code 0 counts up from 0 to the active period and then wraps to 0. The direction output is 0.
- R4: Mode code 1 counts down. From 0 it reloads the active period, then decrements. The direction output is 1.
- R5: Mode code 2 counts from 0 up to the active period and back down to 0. The direction output turns to 1 on the tick that reaches the period and to 0 on the tick that reaches zero.
- R6: With control bit 2 clear, a period write goes to the shadow copy. The active period takes the shadow value on the tick that brings the counter to zero, or on any clock while stopped at zero. With bit 2 set, the write changes the active period at once.
- R7: The compare value follows the same rule as R6, selected by control bit 3.
- R8: The PWM output goes high one clock after the counter equals the active compare value with direction 0. It goes low one clock after such a match with direction 1.
- R9: A counter write (select 3) leaves the count unchanged until the next time-base tick, which loads the written value.
- R10: While run enable is low, the prescaler is cleared, the counter holds its value and all events are low.
- R11: The zero, period, compare-up and compare-down events are levels that stay high for as long as the counter holds the matching value, for one time-base tick.
- R12: Reset clears the counter to 0, sets the direction to 0, drives the PWM output low and clears all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_run | input | 1 | Global time-base run enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 compare, 3 counter |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM output |
| count | output | CNT_W | Current counter value |
| count_down | output | 1 | Direction flag, 1 while counting down |
| ev_zero | output | 1 | Counter equals zero |
| ev_period | output | 1 | Counter equals active period |
| ev_cmp_up | output | 1 | Compare match while counting up |
| ev_cmp_down | output | 1 | Compare match while counting down |

## Verification
Each counting mode runs with a small period, and the bench compares the count sequence step by step. This tells wrap-to-zero apart from reload-from-period and from the turn-around at both ends. A prescaler setting of 12 checks that the count holds on edge 11 and steps on edge 12, which separates the two stage ratios from an off-by-one. Period and compare values are written while the counter runs, once in shadow mode and once in immediate mode. When the new value takes effect shows which load path each uses. Counter writes and run-enable gating are checked at the edges right before and right after the next tick.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_run,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count,
  output logic             count_down,
  output logic             ev_zero,
  output logic             ev_period,
  output logic             ev_cmp_up,
  output logic             ev_cmp_down
);
  localparam int CTRL_W = 10;
  localparam int HS_W   = 4;
  localparam int CK_W   = 7;

  typedef enum logic [1:0] {M_UP = 2'd0, M_DN = 2'd1, M_UD = 2'd2, M_FRZ = 2'd3} mode_t;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, nxt_cnt, prd_sh, prd_act, cmp_sh, cmp_act, wr_val;
  logic              dn_q, nxt_dn, pend_q, pwm_q, go_up;
  logic [HS_W-1:0]   hs_cnt, hs_lim;
  logic [CK_W-1:0]   ck_cnt, ck_lim;
  logic              hs_wrap, ck_wrap, tb_tick, ld_zero, active;
  mode_t             mode;
  logic              prd_imm, cmp_imm;
  logic [2:0]        hs_code, ck_code;

  assign mode    = mode_t'(ctrl_q[1:0]);
  assign prd_imm = ctrl_q[2];
  assign cmp_imm = ctrl_q[3];
  assign hs_code = ctrl_q[6:4];
  assign ck_code = ctrl_q[9:7];

  // cascaded prescaler
  assign hs_lim  = (hs_code == 3'd0) ? '0 : ({hs_code, 1'b0} - 4'd1);
  assign ck_lim  = CK_W'((8'd1 << ck_code) - 8'd1);
  assign hs_wrap = hs_cnt >= hs_lim;
  assign ck_wrap = ck_cnt >= ck_lim;
  assign tb_tick = tb_run & hs_wrap & ck_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt <= '0;
      ck_cnt <= '0;
    end else if (!tb_run) begin
      hs_cnt <= '0;
      ck_cnt <= '0;
    end else if (hs_wrap) begin
      hs_cnt <= '0;
      ck_cnt <= ck_wrap ? '0 : ck_cnt + 1'b1;
    end else begin
      hs_cnt <= hs_cnt + 1'b1;
    end
  end

  // next count and direction
  assign go_up = dn_q ? (cnt_q == '0) : (cnt_q < prd_act);

  always_comb begin
    nxt_cnt = cnt_q;
    nxt_dn  = dn_q;
    case (mode)
      M_UP: begin
        nxt_dn  = 1'b0;
        nxt_cnt = (cnt_q >= prd_act) ? '0 : cnt_q + 1'b1;
      end
      M_DN: begin
        nxt_dn  = 1'b1;
        nxt_cnt = (cnt_q == '0) ? prd_act : cnt_q - 1'b1;
      end
      M_UD: begin
        if (prd_act == '0) begin
          nxt_cnt = '0;
          nxt_dn  = 1'b0;
        end else if (go_up) begin
          nxt_cnt = cnt_q + 1'b1;
          nxt_dn  = (cnt_q + 1'b1) >= prd_act;
        end else begin
          nxt_cnt = cnt_q - 1'b1;
          nxt_dn  = (cnt_q - 1'b1) != '0;
        end
      end
      default: ;
    endcase
    if (pend_q) nxt_cnt = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (tb_tick) begin
      cnt_q <= nxt_cnt;
      dn_q  <= nxt_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wr_val <= '0;
    end else if (wr_en && wr_sel == 2'd3) begin
      pend_q <= 1'b1;
      wr_val <= wr_data;
    end else if (tb_tick) begin
      pend_q <= 1'b0;
    end
  end

  // register writes and shadow loads
  assign ld_zero = (tb_tick && mode != M_FRZ && nxt_cnt == '0) || (!tb_run && cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      prd_sh  <= '0;
      prd_act <= '0;
      cmp_sh  <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_en && wr_sel == 2'd0) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_en && wr_sel == 2'd1) begin
        prd_sh <= wr_data;
        if (prd_imm) prd_act <= wr_data;
      end else if (ld_zero && !prd_imm) begin
        prd_act <= prd_sh;
      end
      if (wr_en && wr_sel == 2'd2) begin
        cmp_sh <= wr_data;
        if (cmp_imm) cmp_act <= wr_data;
      end else if (ld_zero && !cmp_imm) begin
        cmp_act <= cmp_sh;
      end
    end
  end

  // events and action qualifier
  assign active      = tb_run && mode != M_FRZ;
  assign ev_zero     = active && cnt_q == '0;
  assign ev_period   = active && cnt_q == prd_act;
  assign ev_cmp_up   = active && cnt_q == cmp_act && !dn_q;
  assign ev_cmp_down = active && cnt_q == cmp_act && dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pwm_q <= 1'b0;
    else if (ev_cmp_up)   pwm_q <= 1'b1;
    else if (ev_cmp_down) pwm_q <= 1'b0;
  end

  assign pwm_out    = pwm_q;
  assign count      = cnt_q;
  assign count_down = dn_q;

  a_r10_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_run |=> $stable(cnt_q));

  a_r2_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_run && mode == M_FRZ && !pend_q) |=> $stable(cnt_q));

  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && mode == M_UP && !pend_q && cnt_q < prd_act) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r5_down_leg: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && mode == M_UD && !pend_q && dn_q && cnt_q != '0 && prd_act != '0)
      |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r8_pwm_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_up |=> pwm_out);

  a_r8_pwm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_down |=> !pwm_out);
endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tb_run = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pwm_out, count_down, ev_zero, ev_period, ev_cmp_up, ev_cmp_down;
  logic [W-1:0] count;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  pwm_timebase #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tb_run(tb_run), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out), .count(count), .count_down(count_down),
    .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmp_up(ev_cmp_up),
    .ev_cmp_down(ev_cmp_down)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    tb_run = 1'b0;
    wr_en  = 1'b0;
    rst_n  = 1'b0;
    edges(2);
    rst_n  = 1'b1;
    edges(1);
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = W'(data);
    edges(1);
    wr_en   = 1'b0;
  endtask

  task automatic setup(input int ctrl, input int prd, input int cmp);
    do_reset();
    wr(2'd0, ctrl);
    wr(2'd1, prd);
    wr(2'd2, cmp);
    edges(1);
    tb_run = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R12 count", int'(count), 0);
    check("R12 direction", int'(count_down), 0);
    check("R12 pwm", int'(pwm_out), 0);
    check("R10 events low when stopped", int'({ev_zero, ev_period, ev_cmp_up, ev_cmp_down}), 0);
  endtask

  task automatic t_up();
    setup(32'h0, 3, 9);
    for (int i = 1; i <= 8; i++) begin
      edges(1);
      check("R3 up count", int'(count), i % 4);
      check("R3 up direction", int'(count_down), 0);
      check("R11 period event", int'(ev_period), (i % 4 == 3) ? 1 : 0);
      check("R11 zero event", int'(ev_zero), (i % 4 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_down();
    int exp_seq[5] = '{3, 2, 1, 0, 3};
    setup(32'h1, 3, 9);
    for (int i = 0; i < 5; i++) begin
      edges(1);
      check("R4 down count", int'(count), exp_seq[i]);
      check("R4 down direction", int'(count_down), 1);
    end
  endtask

  task automatic t_updown_pwm();
    int cnt_seq[11] = '{1, 2, 3, 4, 3, 2, 1, 0, 1, 2, 3};
    int dn_seq[11]  = '{0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0};
    int pwm_seq[11] = '{0, 0, 1, 1, 1, 1, 0, 0, 0, 0, 1};
    setup(32'h2, 4, 2);
    for (int i = 0; i < 11; i++) begin
      edges(1);
      check("R5 updown count", int'(count), cnt_seq[i]);
      check("R5 updown direction", int'(count_down), dn_seq[i]);
      check("R8 pwm action", int'(pwm_out), pwm_seq[i]);
    end
  endtask

  task automatic t_prescale();
    setup(32'hB0, 9, 9);
    edges(11);
    check("R1 hold before 12th edge", int'(count), 0);
    edges(1);
    check("R1 step on 12th edge", int'(count), 1);
    edges(11);
    check("R1 hold before 24th edge", int'(count), 1);
    edges(1);
    check("R1 step on 24th edge", int'(count), 2);
  endtask

  task automatic t_period_shadow();
    setup(32'h0, 7, 9);
    edges(2);
    wr(2'd1, 3);
    check("R6 shadow write", int'(count), 3);
    edges(1);
    check("R6 old period still active", int'(count), 4);
    edges(3);
    check("R6 reaches old period", int'(count), 7);
    edges(1);
    check("R6 wrap", int'(count), 0);
    edges(3);
    check("R6 new period count", int'(count), 3);
    edges(1);
    check("R6 new period wrap", int'(count), 0);
  endtask

  task automatic t_period_imm();
    setup(32'h4, 7, 9);
    edges(5);
    wr(2'd1, 2);
    check("R6 immediate write", int'(count), 6);
    edges(1);
    check("R6 immediate period wrap", int'(count), 0);
    edges(2);
    check("R6 immediate period top", int'(count), 2);
    edges(1);
    check("R6 immediate period second wrap", int'(count), 0);
  endtask

  task automatic t_cmp(input bit imm);
    setup(imm ? 32'hA : 32'h2, 4, 1);
    edges(1);
    check("R7 initial compare match", int'(ev_cmp_up), 1);
    wr(2'd2, 3);
    edges(1);
    check(imm ? "R7 immediate compare at 3" : "R7 shadow compare at 3", int'(ev_cmp_up), imm ? 1 : 0);
    edges(5);
    check("R7 back at zero", int'(count), 0);
    edges(1);
    check("R7 old compare gone", int'(ev_cmp_up), 0);
    edges(2);
    check("R7 new compare match", int'(ev_cmp_up), 1);
  endtask

  task automatic t_freeze();
    setup(32'h3, 5, 9);
    edges(10);
    check("R2 freeze holds", int'(count), 0);
    check("R2 freeze no zero event", int'(ev_zero), 0);
    check("R11 freeze no period event", int'(ev_period), 0);
  endtask

  task automatic t_cnt_write();
    setup(32'h80, 9, 9);
    edges(2);
    check("R9 first tick", int'(count), 1);
    wr(2'd3, 6);
    check("R9 no early load", int'(count), 1);
    edges(1);
    check("R9 load on tick", int'(count), 6);
    edges(2);
    check("R9 continues after load", int'(count), 7);
  endtask

  task automatic t_run_gate();
    setup(32'h0, 9, 9);
    edges(3);
    check("R10 running", int'(count), 3);
    tb_run = 1'b0;
    edges(5);
    check("R10 holds while stopped", int'(count), 3);
    check("R10 no compare event", int'(ev_cmp_up), 0);
    tb_run = 1'b1;
    edges(1);
    check("R10 resumes", int'(count), 4);
  endtask

  initial begin
    t_reset();
    t_up();
    t_down();
    t_updown_pwm();
    t_prescale();
    t_period_shadow();
    t_period_imm();
    t_cmp(1'b0);
    t_cmp(1'b1);
    t_freeze();
    t_cnt_write();
    t_run_gate();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule